// File: doc/BRIEF.md
# Bit-Manipulation Count and Pack Unit

This block is an execution unit for a scalar integer datapath whose register width is set by the parameter `XLEN` (32 or 64). Each cycle it takes two source operands and a 4-bit operation code and produces one `XLEN`-wide result. It handles three groups of work:

- Bit counting: leading zeros, trailing zeros and set-bit population.
- Logic with one operand inverted, and three ways of packing operand fragments into one word.
- Signed and unsigned minimum/maximum, plus sign extension from a byte or a halfword.

The datapath is purely combinational. One optional register stage, selected by the parameter `OUT_REG`, sits at the output so the unit can be placed in a pipeline slot. Decode upstream drives the operation code and the operands, and the result is written back by the surrounding pipeline.

Top module: `bitcnt_pack_unit`

## Requirements
- R1: Code 0 returns the number of zero bits above the most significant set bit of `src_a`, and returns XLEN when `src_a` is zero.
- R2: Code 1 returns the number of zero bits below the least significant set bit of `src_a`, and returns XLEN when `src_a` is zero.
- R3: Code 2 returns the count of one bits in `src_a`.
- R4: Code 3 returns `src_a & ~src_b`, code 4 returns `src_a | ~src_b`, and code 5 returns `~(src_a ^ src_b)`.
- R5: Code 6 returns the lower half of `src_b` in the upper XLEN/2 bits and the lower half of `src_a` in the lower XLEN/2 bits.
- R6: Code 7 returns the upper half of `src_b` in the upper XLEN/2 bits and the upper half of `src_a` in the lower XLEN/2 bits.
- R7: Code 8 returns `src_a[7:0]` in bits 7:0 and `src_b[7:0]` in bits 15:8, with every bit above 15 zero.
- R8: Code 9 returns the smaller and code 10 the larger of the two operands, compared as two's-complement signed values.
- R9: Code 11 returns the smaller and code 12 the larger of the two operands, compared as unsigned values.
- R10: Code 13 copies `src_a[7]` into every bit above bit 7, and code 14 copies `src_a[15]` into every bit above bit 15.
- R11: Code 15 is unused and returns zero regardless of the operands.
- R12: With `OUT_REG`=1 (the default), the result appears on the first rising clock edge after the inputs are applied, and synchronous reset clears it to zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the optional output register |
| rst | input | 1 | Synchronous active-high reset of the output register |
| op_sel | input | 4 | Operation code |
| src_a | input | XLEN | First source operand |
| src_b | input | XLEN | Second source operand |
| result | output | XLEN | Operation result |

## Verification
The bench targets the following corner cases and the faults each one would expose:

- Zero operands for the two zero counts. A design that returns XLEN-1, or that wraps a narrow counter to zero, fails here.
- Single set bits at both word ends. These catch an off-by-one in the leading or trailing scan.
- Operands that differ only in sign for min/max. Swapping the signed and unsigned compare, or the min and max sense, changes the answer.
- Packing with distinct half and byte patterns. These expose halves placed in the wrong position or nonzero upper bits in the byte pack.
- Sign-extension boundaries, where bit 7 or bit 15 alone decides the fill.
- The unused code with all-ones operands, which must still return zero.

A random sweep against an independent model in the bench covers the remaining combinations.

// File: rtl/bmu_pkg.sv
package bmu_pkg;

    localparam int OP_W = 4;

    typedef enum logic [OP_W-1:0] {
        OP_CLZ   = 4'd0,
        OP_CTZ   = 4'd1,
        OP_CPOP  = 4'd2,
        OP_ANDN  = 4'd3,
        OP_ORN   = 4'd4,
        OP_XNOR  = 4'd5,
        OP_PACK  = 4'd6,
        OP_PACKU = 4'd7,
        OP_PACKH = 4'd8,
        OP_MIN   = 4'd9,
        OP_MAX   = 4'd10,
        OP_MINU  = 4'd11,
        OP_MAXU  = 4'd12,
        OP_SEXTB = 4'd13,
        OP_SEXTH = 4'd14,
        OP_RSVD  = 4'd15
    } bmu_op_e;

    // Width of a count that can hold the value n.
    function automatic int cnt_width(input int n);
        return $clog2(n + 1);
    endfunction

endpackage

// File: rtl/bmu_count.sv
module bmu_count #(
    parameter int XLEN = 32,
    localparam int CW = bmu_pkg::cnt_width(XLEN)
) (
    input  logic [XLEN-1:0] val,
    output logic [CW-1:0]   lead_zeros,
    output logic [CW-1:0]   trail_zeros,
    output logic [CW-1:0]   ones
);

    // Leading-zero scan: the count keeps growing until the first set bit from the top.
    always_comb begin
        logic seen;
        seen       = 1'b0;
        lead_zeros = '0;
        for (int i = XLEN - 1; i >= 0; i--) begin
            if (val[i]) seen = 1'b1;
            if (!seen) lead_zeros = lead_zeros + CW'(1);
        end
    end

    // Trailing-zero scan: the same walk from the bottom.
    always_comb begin
        logic seen;
        seen        = 1'b0;
        trail_zeros = '0;
        for (int i = 0; i < XLEN; i++) begin
            if (val[i]) seen = 1'b1;
            if (!seen) trail_zeros = trail_zeros + CW'(1);
        end
    end

    always_comb begin
        ones = '0;
        for (int i = 0; i < XLEN; i++) begin
            ones = ones + CW'(val[i]);
        end
    end

endmodule

// File: rtl/bmu_logic_pack.sv
module bmu_logic_pack #(
    parameter int XLEN = 32,
    localparam int HALF = XLEN / 2
) (
    input  logic [XLEN-1:0] a,
    input  logic [XLEN-1:0] b,
    output logic [XLEN-1:0] and_inv,
    output logic [XLEN-1:0] or_inv,
    output logic [XLEN-1:0] eq_bits,
    output logic [XLEN-1:0] pack_lo,
    output logic [XLEN-1:0] pack_hi,
    output logic [XLEN-1:0] pack_byte
);

    assign and_inv = a & ~b;
    assign or_inv  = a | ~b;
    assign eq_bits = ~(a ^ b);

    // Lower halves of both operands, b on top.
    assign pack_lo = {b[HALF-1:0], a[HALF-1:0]};

    // Upper halves of both operands, b on top.
    assign pack_hi = {b[XLEN-1:HALF], a[XLEN-1:HALF]};

    // Two low bytes side by side, everything above zero.
    assign pack_byte = {{(XLEN-16){1'b0}}, b[7:0], a[7:0]};

endmodule

// File: rtl/bmu_minmax_ext.sv
module bmu_minmax_ext #(
    parameter int XLEN = 32
) (
    input  logic [XLEN-1:0] a,
    input  logic [XLEN-1:0] b,
    output logic [XLEN-1:0] s_min,
    output logic [XLEN-1:0] s_max,
    output logic [XLEN-1:0] u_min,
    output logic [XLEN-1:0] u_max,
    output logic [XLEN-1:0] ext_byte,
    output logic [XLEN-1:0] ext_half
);

    logic a_lt_s;
    logic a_lt_u;

    assign a_lt_s = $signed(a) < $signed(b);
    assign a_lt_u = a < b;

    assign s_min = a_lt_s ? a : b;
    assign s_max = a_lt_s ? b : a;
    assign u_min = a_lt_u ? a : b;
    assign u_max = a_lt_u ? b : a;

    assign ext_byte = {{(XLEN-8){a[7]}}, a[7:0]};
    assign ext_half = {{(XLEN-16){a[15]}}, a[15:0]};

endmodule

// File: rtl/bitcnt_pack_unit.sv
module bitcnt_pack_unit #(
    parameter int XLEN    = 32,
    parameter bit OUT_REG = 1'b1
) (
    input  logic            clk,
    input  logic            rst,
    input  logic [3:0]      op_sel,
    input  logic [XLEN-1:0] src_a,
    input  logic [XLEN-1:0] src_b,
    output logic [XLEN-1:0] result
);
    import bmu_pkg::*;

    localparam int CW = cnt_width(XLEN);

    bmu_op_e         op;
    logic [CW-1:0]   clz_cnt, ctz_cnt, pop_cnt;
    logic [XLEN-1:0] andn_v, orn_v, xnor_v, pack_v, packu_v, packh_v;
    logic [XLEN-1:0] smin_v, smax_v, umin_v, umax_v, sextb_v, sexth_v;
    logic [XLEN-1:0] result_next;

    assign op = bmu_op_e'(op_sel);

    bmu_count #(.XLEN(XLEN)) u_count (
        .val         (src_a),
        .lead_zeros  (clz_cnt),
        .trail_zeros (ctz_cnt),
        .ones        (pop_cnt)
    );

    bmu_logic_pack #(.XLEN(XLEN)) u_logic_pack (
        .a         (src_a),
        .b         (src_b),
        .and_inv   (andn_v),
        .or_inv    (orn_v),
        .eq_bits   (xnor_v),
        .pack_lo   (pack_v),
        .pack_hi   (packu_v),
        .pack_byte (packh_v)
    );

    bmu_minmax_ext #(.XLEN(XLEN)) u_minmax (
        .a        (src_a),
        .b        (src_b),
        .s_min    (smin_v),
        .s_max    (smax_v),
        .u_min    (umin_v),
        .u_max    (umax_v),
        .ext_byte (sextb_v),
        .ext_half (sexth_v)
    );

    always_comb begin
        unique case (op)
            OP_CLZ:   result_next = XLEN'(clz_cnt);
            OP_CTZ:   result_next = XLEN'(ctz_cnt);
            OP_CPOP:  result_next = XLEN'(pop_cnt);
            OP_ANDN:  result_next = andn_v;
            OP_ORN:   result_next = orn_v;
            OP_XNOR:  result_next = xnor_v;
            OP_PACK:  result_next = pack_v;
            OP_PACKU: result_next = packu_v;
            OP_PACKH: result_next = packh_v;
            OP_MIN:   result_next = smin_v;
            OP_MAX:   result_next = smax_v;
            OP_MINU:  result_next = umin_v;
            OP_MAXU:  result_next = umax_v;
            OP_SEXTB: result_next = sextb_v;
            OP_SEXTH: result_next = sexth_v;
            default:  result_next = '0;
        endcase
    end

    generate
        if (OUT_REG) begin : g_out_reg
            logic [XLEN-1:0] result_q;
            always_ff @(posedge clk) begin
                if (rst) result_q <= '0;
                else     result_q <= result_next;
            end
            assign result = result_q;
        end else begin : g_out_comb
            assign result = result_next;
        end
    endgenerate

    // Counts of a zero operand saturate at the word width.
    assert_clz_zero_R1: assert property (@(posedge clk) disable iff (rst)
        (src_a == '0) |-> (clz_cnt == CW'(XLEN)));
    assert_ctz_zero_R2: assert property (@(posedge clk) disable iff (rst)
        (src_a == '0) |-> (ctz_cnt == CW'(XLEN)));
    // A single set bit splits the word between the two zero counts.
    assert_single_bit_split_R2: assert property (@(posedge clk) disable iff (rst)
        $onehot(src_a) |-> (int'(clz_cnt) + int'(ctz_cnt) == XLEN - 1));
    assert_pop_matches_R3: assert property (@(posedge clk) disable iff (rst)
        1'b1 |-> (int'(pop_cnt) == $countones(src_a)));
    assert_packh_upper_zero_R7: assert property (@(posedge clk) disable iff (rst)
        1'b1 |-> (packh_v[XLEN-1:16] == '0));
    assert_signed_order_R8: assert property (@(posedge clk) disable iff (rst)
        1'b1 |-> ($signed(smin_v) <= $signed(smax_v)));
    assert_unsigned_order_R9: assert property (@(posedge clk) disable iff (rst)
        1'b1 |-> (umin_v <= umax_v));
    assert_unused_zero_R11: assert property (@(posedge clk) disable iff (rst)
        (op_sel == 4'hF) |-> (result_next == '0));

endmodule

// File: tb/test_bitcnt_pack_unit.sv
module test_bitcnt_pack_unit;

    localparam int XLEN = 32;
    localparam int NVEC = 25;

    logic            clk = 1'b0;
    logic            rst = 1'b1;
    logic [3:0]      op_sel = '0;
    logic [XLEN-1:0] src_a = '0;
    logic [XLEN-1:0] src_b = '0;
    logic [XLEN-1:0] result;

    int n_checks = 0;
    int n_fails  = 0;
    bit finished = 0;

    always #2 clk = ~clk;

    bitcnt_pack_unit #(.XLEN(XLEN), .OUT_REG(1'b1)) i_bitcnt_pack_unit (
        .clk    (clk),
        .rst    (rst),
        .op_sel (op_sel),
        .src_a  (src_a),
        .src_b  (src_b),
        .result (result)
    );

    // {op, a, b, expected}
    localparam logic [99:0] VEC [NVEC] = '{
        {4'd0,  32'h00000000, 32'h00000000, 32'd32},       // R1
        {4'd0,  32'h00010000, 32'h00000000, 32'd15},       // R1
        {4'd0,  32'h80000000, 32'h00000000, 32'd0},        // R1
        {4'd1,  32'h00000000, 32'h00000000, 32'd32},       // R2
        {4'd1,  32'h00000100, 32'h00000000, 32'd8},        // R2
        {4'd1,  32'h80000000, 32'h00000000, 32'd31},       // R2
        {4'd2,  32'hFFFFFFFF, 32'h00000000, 32'd32},       // R3
        {4'd2,  32'hF0F00001, 32'h00000000, 32'd9},        // R3
        {4'd3,  32'hFF00FF00, 32'h0F0F0F0F, 32'hF000F000}, // R4
        {4'd4,  32'h00000000, 32'h0000FFFF, 32'hFFFF0000}, // R4
        {4'd5,  32'h12345678, 32'h12345678, 32'hFFFFFFFF}, // R4
        {4'd6,  32'hAAAA1234, 32'hBBBB5678, 32'h56781234}, // R5
        {4'd7,  32'h1234AAAA, 32'h5678BBBB, 32'h56781234}, // R6
        {4'd8,  32'hFFFFFF12, 32'hFFFFFF34, 32'h00003412}, // R7
        {4'd9,  32'hFFFFFFFF, 32'h00000001, 32'hFFFFFFFF}, // R8
        {4'd10, 32'hFFFFFFFF, 32'h00000001, 32'h00000001}, // R8
        {4'd9,  32'h80000000, 32'h7FFFFFFF, 32'h80000000}, // R8
        {4'd11, 32'hFFFFFFFF, 32'h00000001, 32'h00000001}, // R9
        {4'd12, 32'hFFFFFFFF, 32'h00000001, 32'hFFFFFFFF}, // R9
        {4'd12, 32'h80000000, 32'h7FFFFFFF, 32'h80000000}, // R9
        {4'd13, 32'h00000080, 32'h00000000, 32'hFFFFFF80}, // R10
        {4'd13, 32'hFFFFFF7F, 32'h00000000, 32'h0000007F}, // R10
        {4'd14, 32'h00008001, 32'h00000000, 32'hFFFF8001}, // R10
        {4'd14, 32'h12347FFF, 32'h00000000, 32'h00007FFF}, // R10
        {4'd15, 32'hFFFFFFFF, 32'hFFFFFFFF, 32'h00000000}  // R11
    };

    function automatic string req_of(input logic [3:0] op);
        case (op)
            4'd0:                 return "R1";
            4'd1:                 return "R2";
            4'd2:                 return "R3";
            4'd3, 4'd4, 4'd5:     return "R4";
            4'd6:                 return "R5";
            4'd7:                 return "R6";
            4'd8:                 return "R7";
            4'd9, 4'd10:          return "R8";
            4'd11, 4'd12:         return "R9";
            4'd13, 4'd14:         return "R10";
            default:              return "R11";
        endcase
    endfunction

    // Independent behavioural model.
    function automatic logic [XLEN-1:0] model(input logic [3:0] op,
                                              input logic [XLEN-1:0] a,
                                              input logic [XLEN-1:0] b);
        int k;
        logic signed [XLEN-1:0] sa, sb;
        sa = a; sb = b;
        case (op)
            4'd0: begin k = 0; while (k < XLEN && a[XLEN-1-k] == 1'b0) k++; return XLEN'(k); end
            4'd1: begin k = 0; while (k < XLEN && a[k] == 1'b0) k++; return XLEN'(k); end
            4'd2: return XLEN'($countones(a));
            4'd3: return a & ~b;
            4'd4: return a | ~b;
            4'd5: return ~(a ^ b);
            4'd6: return (b << (XLEN/2)) | ((a << (XLEN/2)) >> (XLEN/2));
            4'd7: return ((b >> (XLEN/2)) << (XLEN/2)) | (a >> (XLEN/2));
            4'd8: return XLEN'({b[7:0], a[7:0]});
            4'd9:  return (sa < sb) ? a : b;
            4'd10: return (sa > sb) ? a : b;
            4'd11: return (a < b) ? a : b;
            4'd12: return (a > b) ? a : b;
            4'd13: return XLEN'($signed(a[7:0]));
            4'd14: return XLEN'($signed(a[15:0]));
            default: return '0;
        endcase
    endfunction

    task automatic check(input string req, input logic [XLEN-1:0] exp);
        n_checks++;
        if (result !== exp) begin
            n_fails++;
            $display("FAIL %s: op=%0d a=%h b=%h actual=%h expected=%h",
                     req, op_sel, src_a, src_b, result, exp);
        end
    endtask

    // Apply at a falling edge; the registered result is sampled one falling edge later.
    task automatic apply(input logic [3:0] op, input logic [XLEN-1:0] a,
                         input logic [XLEN-1:0] b, input logic [XLEN-1:0] exp);
        @(negedge clk);
        op_sel = op; src_a = a; src_b = b;
        @(negedge clk);
        check(req_of(op), exp);
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1;
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
            $finish;
        end
    endtask

    initial begin
        #(200000 * 4);
        n_checks++;
        n_fails++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        finish_run();
    end

    initial begin
        // R12: reset clears the output register even with live inputs.
        op_sel = 4'd5; src_a = 32'h0; src_b = 32'h0;
        repeat (3) @(negedge clk);
        check("R12", '0);
        rst = 1'b0;

        for (int i = 0; i < NVEC; i++) begin
            apply(VEC[i][99:96], VEC[i][95:64], VEC[i][63:32], VEC[i][31:0]);
        end

        // R12: result holds the previous value until the next rising edge.
        apply(4'd3, 32'hFFFFFFFF, 32'h0, 32'hFFFFFFFF);
        @(negedge clk);
        op_sel = 4'd15;
        #1;
        check("R12", 32'hFFFFFFFF);
        @(negedge clk);
        check("R11", '0);

        // R12: synchronous reset clears a nonzero result.
        apply(4'd2, 32'h0000000F, 32'h0, 32'd4);
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        check("R12", '0);
        rst = 1'b0;

        // Random sweep against the model.
        for (int i = 0; i < 400; i++) begin
            logic [3:0]      op;
            logic [XLEN-1:0] a, b;
            op = 4'($urandom % 16);
            a  = $urandom;
            b  = $urandom;
            if (i % 7 == 0) a = XLEN'(1) << ($urandom % XLEN);
            if (i % 11 == 0) b = a;
            apply(op, a, b, model(op, a, b));
        end

        finish_run();
    end

endmodule